// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

This block collects up to 32 interrupt request lines and raises one request towards a processor. Each line is fixed as edge or level sensitive at build time through a parameter mask. Captured requests land in a status register, and an enable mask qualifies them into a pending set. A vector register reports the index of the lowest-numbered pending line. Software uses a single-cycle word-addressed bus with a write strobe and a combinational read path to inspect and steer it.

Two master control bits act independently. One allows input capture and the request output. The other allows only the request output. Enable bits can be changed one at a time through set and clear command offsets. Edge-captured requests are retired by writing ones to an acknowledge command offset.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Word offsets (bus_addr) decode as 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control. A write to offset 0, 2 or 7 stores the data, and a read returns it (master control keeps data bits 1:0 only).
- R2: Reading offset 1 returns status AND enable at every cycle.
- R3: Reading offset 6 returns the index of the lowest-numbered set pending bit, or all ones when pending is zero.
- R4: irq_out is high exactly when master bit 0 is 1, master bit 1 is 1 and pending is non-zero.
- R5: A write to offset 3 clears each status bit of an edge source whose data bit is 1. A write to offset 4 sets, and a write to offset 5 clears, each enable bit whose data bit is 1. All other bits are unchanged.
- R6: While master bit 1 is 0, input changes do not alter status and irq_out is low.
- R7: With master bit 1 set, a level source's status bit equals its input as sampled at the previous clock edge.
- R8: With master bit 1 set, an edge source's status bit is set by a 0-to-1 change of its input between consecutive clock edges. It stays set until it is acknowledged or overwritten.
- R9: Offsets 3, 4 and 5 read as zero, writes to offsets 1 and 6 have no effect, and reads of offsets 8 and above return zero.
- R10: After reset every register reads zero, the vector reads all ones and irq_out is low.
- R11: An acknowledge and a new rising edge on the same edge source in the same cycle leave that status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Interrupt request lines |
| bus_addr | input | ADDR_W | Word offset for read and write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_out | output | 1 | Request to the processor |

## Verification
An acknowledge write and a fresh rising edge on the same edge source can fall in the same clock cycle. The two intents then conflict on one status bit. The bench provokes this directly by asserting the write strobe on the acknowledge offset in the cycle where the line rises, and checks that the bit reads back set. It repeats the write with the line held high and checks that the bit then clears. Random stimulus also mixes line toggles with acknowledge and enable commands, and every offset is read back against a model built from the requirements.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
    typedef enum logic [2:0] {
        OFF_STATUS = 3'd0,
        OFF_PEND   = 3'd1,
        OFF_ENABLE = 3'd2,
        OFF_ACK    = 3'd3,
        OFF_SETEN  = 3'd4,
        OFF_CLREN  = 3'd5,
        OFF_VECTOR = 3'd6,
        OFF_MASTER = 3'd7
    } vic_off_e;

    localparam int MST_OUT = 0;
    localparam int MST_CAP = 1;
    localparam int NUM_OFF = 8;
endpackage

// File: rtl/vic_capture.sv
`timescale 1ns/1ps
module vic_capture #(
    parameter int NUM_SRC = 32,
    parameter logic [NUM_SRC-1:0] EDGE_SRC = '0
) (
    input  logic [NUM_SRC-1:0] base,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] prev_in,
    input  logic               cap_en,
    output logic [NUM_SRC-1:0] status_next
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (EDGE_SRC[g]) begin : g_edge
            // a new rise overrides any clear applied to base
            assign status_next[g] = base[g] | (cap_en & irq_in[g] & ~prev_in[g]);
        end else begin : g_level
            assign status_next[g] = cap_en ? irq_in[g] : base[g];
        end
    end
endmodule

// File: rtl/vic_lowest.sv
`timescale 1ns/1ps
module vic_lowest #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_rd_mux.sv
`timescale 1ns/1ps
module vic_rd_mux
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] pending,
    input  logic [NUM_SRC-1:0] enable,
    input  logic [DATA_W-1:0]  vector,
    input  logic [1:0]         master,
    output logic [DATA_W-1:0]  rdata
);
    logic in_map;
    assign in_map = (32'(addr) < NUM_OFF);

    always_comb begin
        rdata = '0;
        if (in_map) begin
            case (vic_off_e'(addr[2:0]))
                OFF_STATUS: rdata = DATA_W'(status);
                OFF_PEND:   rdata = DATA_W'(pending);
                OFF_ENABLE: rdata = DATA_W'(enable);
                OFF_VECTOR: rdata = vector;
                OFF_MASTER: rdata = DATA_W'(master);
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter logic [NUM_SRC-1:0] EDGE_SRC = NUM_SRC'(32'h0000_FFFF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] prev;
        logic [1:0]         master;
    } vic_state_t;

    vic_state_t st_d, st_q;

    logic               wr_hit;
    vic_off_e           wr_off;
    logic [NUM_SRC-1:0] wsrc;
    logic [NUM_SRC-1:0] status_base;
    logic [NUM_SRC-1:0] status_next;
    logic [NUM_SRC-1:0] pending;
    logic               pend_found;
    logic [IDX_W-1:0]   pend_idx;
    logic [DATA_W-1:0]  vector;

    assign wr_hit = bus_wr && (32'(bus_addr) < NUM_OFF);
    assign wr_off = vic_off_e'(bus_addr[2:0]);
    assign wsrc   = bus_wdata[NUM_SRC-1:0];

    // status after bus effects, before input capture
    always_comb begin
        status_base = st_q.status;
        if (wr_hit && wr_off == OFF_STATUS) status_base = wsrc;
        if (wr_hit && wr_off == OFF_ACK)    status_base = st_q.status & ~wsrc;
    end

    vic_capture #(
        .NUM_SRC  (NUM_SRC),
        .EDGE_SRC (EDGE_SRC)
    ) u_cap (
        .base        (status_base),
        .irq_in      (irq_in),
        .prev_in     (st_q.prev),
        .cap_en      (st_q.master[MST_CAP]),
        .status_next (status_next)
    );

    always_comb begin
        st_d        = st_q;
        st_d.prev   = irq_in;
        st_d.status = status_next;
        if (wr_hit) begin
            case (wr_off)
                OFF_ENABLE: st_d.enable = wsrc;
                OFF_SETEN:  st_d.enable = st_q.enable | wsrc;
                OFF_CLREN:  st_d.enable = st_q.enable & ~wsrc;
                OFF_MASTER: st_d.master = bus_wdata[1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.status & st_q.enable;

    vic_lowest #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_enc (
        .req   (pending),
        .found (pend_found),
        .idx   (pend_idx)
    );

    assign vector  = pend_found ? DATA_W'(pend_idx) : '1;
    assign irq_out = st_q.master[MST_OUT] & st_q.master[MST_CAP] & (|pending);

    vic_rd_mux #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_rd (
        .addr    (bus_addr),
        .status  (st_q.status),
        .pending (pending),
        .enable  (st_q.enable),
        .vector  (vector),
        .master  (st_q.master),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/vic_checker.sv
`timescale 1ns/1ps
module vic_checker #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter logic [NUM_SRC-1:0] EDGE_SRC = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [1:0]         master_q,
    input logic [DATA_W-1:0]  vector
);
    localparam logic [NUM_SRC-1:0] LVL = ~EDGE_SRC;

    logic st_write;
    assign st_write = bus_wr && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(3));

    a_r4_out_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !master_q[0] |-> !irq_out);

    a_r6_out_low: assert property (@(posedge clk) disable iff (!rst_n)
        !master_q[1] |-> !irq_out);

    a_r6_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_q[1] && !st_write) |=> $stable(status_q));

    a_r5_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4))
        |=> ((enable_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    a_r5_clr_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(5))
        |=> ((enable_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    a_r7_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        master_q[1] |=> ((status_q & LVL) == ($past(irq_in) & LVL)));

    a_r8_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_write |=> ((status_q & $past(status_q) & EDGE_SRC) == ($past(status_q) & EDGE_SRC)));

    a_r3_vector_valid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (vector != '1));
endmodule

bind irq_vector_ctrl vic_checker #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .EDGE_SRC (EDGE_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .status_q  (st_q.status),
    .enable_q  (st_q.enable),
    .master_q  (st_q.master),
    .vector    (vector)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    localparam logic [31:0] EDGE = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_st = '0, m_en = '0, m_prev = '0;
    logic [1:0]  m_mst = '0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] vec_of(logic [31:0] p);
        for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
        return '1;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        case (a)
            0: return m_st;
            1: return m_st & m_en;
            2: return m_en;
            6: return vec_of(m_st & m_en);
            7: return {30'd0, m_mst};
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(int a);
        case (a)
            0: return "R7/R8 status";
            1: return "R2 pending";
            2: return "R5 enable";
            6: return "R3 vector";
            7: return "R1 master";
            default: return "R9 zero read";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance one clock, updating the model from the driven inputs
    task automatic step();
        logic [31:0] ns, ne;
        logic [1:0]  nm;
        ns = m_st; ne = m_en; nm = m_mst;
        if (bus_wr) begin
            case (bus_addr)
                4'd0: ns = bus_wdata;
                4'd2: ne = bus_wdata;
                4'd3: ns = ns & ~bus_wdata;
                4'd4: ne = ne | bus_wdata;
                4'd5: ne = ne & ~bus_wdata;
                4'd7: nm = bus_wdata[1:0];
                default: ;
            endcase
        end
        if (m_mst[1]) ns = (ns & EDGE) | (irq_in & ~EDGE) | (irq_in & ~m_prev & EDGE);
        @(posedge clk);
        m_st = ns; m_en = ne; m_mst = nm; m_prev = irq_in;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        step();
    endtask

    task automatic rd_chk(int a, string req);
        bus_wr = 1'b0; bus_addr = 4'(a);
        #0.2;
        chk(req, bus_rdata, exp_rd(a));
    endtask

    task automatic check_all(string tag);
        for (int a = 0; a < 16; a++) rd_chk(a, {tag, " ", req_of(a)});
        chk({tag, " R4 irq_out"}, 32'(irq_out),
            32'(m_mst[0] & m_mst[1] & (|(m_st & m_en))));
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        check_all("R10");
        rd_chk(6, "R10 vector all ones");

        // R1 stored offsets
        wr(2, 32'hA5A5_0001); rd_chk(2, "R1 enable store");
        wr(0, 32'h0000_0100); rd_chk(0, "R1 status store");
        wr(7, 32'hFFFF_FFFD); rd_chk(7, "R1 master store");
        chk("R4 bit1 clear keeps low", 32'(irq_out), 32'd0);
        wr(0, 32'h0); wr(2, 32'hFFFF_FFFF); wr(7, 32'h3);

        // R8 edge source 3
        irq_in[3] = 1'b1; step();
        rd_chk(0, "R8 edge captured");
        rd_chk(6, "R3 vector index 3");
        chk("R4 irq high", 32'(irq_out), 32'd1);
        irq_in[3] = 1'b0; step();
        rd_chk(0, "R8 edge held after drop");

        // R7 level source 20
        irq_in[20] = 1'b1; step();
        rd_chk(0, "R7 level set");
        rd_chk(6, "R3 lowest wins");
        irq_in[20] = 1'b0; step();
        rd_chk(0, "R7 level cleared");

        // R11 ack and rise together on source 3
        irq_in[3] = 1'b1; wr(3, 32'h8);
        rd_chk(0, "R11 edge beats ack");
        wr(3, 32'h8);
        rd_chk(0, "R5 ack clears");
        chk("R3 none pending", bus_rdata, 32'h0);
        rd_chk(6, "R3 vector none");
        irq_in[3] = 1'b0; step();

        // R5 set/clear enable
        wr(5, 32'h0000_00F0); rd_chk(2, "R5 clear enable");
        wr(4, 32'h0000_0030); rd_chk(2, "R5 set enable");

        // R6 capture disabled
        wr(7, 32'h1);
        irq_in[5] = 1'b1; irq_in[25] = 1'b1; step(); step();
        rd_chk(0, "R6 no capture");
        chk("R6 irq low", 32'(irq_out), 32'd0);
        irq_in[5] = 1'b0; irq_in[25] = 1'b0; step();
        wr(7, 32'h3);

        // R9 writes to derived offsets ignored
        wr(0, 32'h0000_0040);
        wr(1, 32'hFFFF_FFFF); rd_chk(1, "R9 pending not writable");
        wr(6, 32'h0000_0000); rd_chk(6, "R9 vector not writable");
        wr(9, 32'hFFFF_FFFF); check_all("R9");

        // random mix
        for (int it = 0; it < 600; it++) begin
            if ($urandom_range(0, 2) == 0) irq_in = irq_in ^ ($urandom() & $urandom() & $urandom());
            if ($urandom_range(0, 1) == 0) begin
                int a;
                logic [31:0] d;
                a = $urandom_range(0, 10);
                d = ($urandom_range(0, 1) == 0) ? $urandom() : ($urandom() & $urandom());
                if (a == 7) d = ($urandom_range(0, 3) == 0) ? $urandom() : 32'h3;
                wr(a, d);
            end else begin
                step();
            end
            check_all("RND");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule